// File: doc/BRIEF.md
# Read-Tracking Scrub Sequencer

This block supports a memory array that defers its error check from reads to the moment a value is about to be overwritten. A value that was read but never overwritten has not been checked yet. The block keeps one mark bit per entry. A read marks the entry, and a write clears the mark, because the write path already ran its own read-before-write check.

When a trigger arrives, the block walks the array in ascending address order. It issues a read-check on each marked entry, or on every entry in full mode. It writes back the corrected value for a correctable error and gathers sticky correctable and uncorrectable flags. The triggers are:
- the end of an atomic sequence,
- a context switch or kernel entry,
- an intercepted exception,
- an optional periodic timer.

At the end of the walk the block raises a one-cycle done pulse and drives the recovery interface:
- Discard is signalled on any error.
- Restart is signalled when every error found was correctable.
- An intercepted exception is forwarded, tagged when an uncorrectable error was found in this array.

Host accesses are stalled while a walk is in progress.

Top module: `scrub_seq`

## Requirements
- R1: A host access accepted while idle (acc_valid_i=1, busy_o=0) marks the addressed entry when acc_we_i=0 and unmarks it when acc_we_i=1.
- R2: A pulse on trig_seq_end_i, trig_ctx_i or trig_exc_i while idle starts a walk: busy_o is high from the next cycle through the done cycle. While busy, trig_seq_end_i and trig_ctx_i are ignored.
- R3: A walk visits addresses 0 to N-1 in ascending order and issues a read-check (arr_req_o=1, arr_we_o=0) only on marked entries, or on all entries if full_mode_i was high at the trigger. Each unmarked entry costs one cycle. With a one-cycle array response, busy_o lasts N + reads + write-backs + 1 cycles.
- R4: Every entry that is read-checked is unmarked, so a second walk issues no reads.
- R5: arr_stat_i encoding: 2'b00 clean, 2'b01 correctable, 2'b10 or 2'b11 uncorrectable. A correctable response is followed in the next cycle by a write (arr_req_o=1, arr_we_o=1) of arr_fix_i to the same address.
- R6: done_o is a one-cycle pulse at the end of a walk. ce_o and ue_o give the sticky correctable and uncorrectable flags of that walk and hold until the next walk starts.
- R7: With done_o, discard_o is high if any error was found. restart_o is high if errors were found and all of them were correctable.
- R8: With done_o, exc_o is high if an exception trigger started the walk or arrived during it. exc_ue_o is then high only if an uncorrectable error was found. With no error, the exception passes with discard_o=0.
- R9: Host accesses presented while busy_o is high are stalled and change no mark.
- R10: With tmr_en_i held high while idle, a walk starts on the PERIOD-th clock edge after enabling, with busy_o visible after that edge.
- R11: An uncorrectable response causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host access present |
| acc_we_i | input | 1 | Host access is a write |
| acc_addr_i | input | ADDR_W | Host access entry |
| trig_seq_end_i | input | 1 | Atomic sequence end trigger |
| trig_ctx_i | input | 1 | Context switch / kernel entry trigger |
| trig_exc_i | input | 1 | Intercepted exception trigger |
| tmr_en_i | input | 1 | Periodic walk enable |
| full_mode_i | input | 1 | Check all entries regardless of marks |
| arr_req_o | output | 1 | Array operation request |
| arr_we_o | output | 1 | Array operation is a write-back |
| arr_addr_o | output | ADDR_W | Array entry |
| arr_wdata_o | output | DATA_W | Corrected value to write back |
| arr_rvalid_i | input | 1 | Read-check response valid |
| arr_stat_i | input | 2 | Read-check outcome |
| arr_fix_i | input | DATA_W | Corrected value from the checker |
| busy_o | output | 1 | Walk active, host accesses stalled |
| done_o | output | 1 | Walk finished pulse |
| ce_o | output | 1 | Correctable error seen in last walk |
| ue_o | output | 1 | Uncorrectable error seen in last walk |
| discard_o | output | 1 | Discard speculative state |
| restart_o | output | 1 | Restart the atomic sequence |
| exc_o | output | 1 | Forward intercepted exception |
| exc_ue_o | output | 1 | Exception carries uncorrectable-array tag |

## Verification
The main function is tried with every one of the 256 mark patterns of an 8-entry array, built from mixes of host reads and writes. For each pattern, the log of read-checks is compared against the set bits in ascending order, and the walk length tells single-cycle skips apart from issued checks. Each pattern is followed by a second walk, which separates entries that were unmarked by the check from entries left marked.

Single correctable and uncorrectable faults are swept across every address, followed by a mixed case. These tell write-back from no write-back, and restart from discard-only. Separate runs cover the remaining features:
- full mode,
- exceptions with and without errors,
- triggers and host accesses arriving mid-walk,
- the timer period.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_WAIT, S_FIX, S_DONE
  } scr_state_e;

  localparam logic [1:0] CHK_CLEAN = 2'b00;
  localparam logic [1:0] CHK_CORR  = 2'b01;
endpackage

// File: rtl/scrub_mark.sv
module scrub_mark #(
  parameter int N      = 8,
  parameter int ADDR_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  output logic [N-1:0]      marks_o
);
  logic host_hit;
  assign host_hit = acc_valid_i && !busy_i;

  for (genvar i = 0; i < N; i++) begin : g_mark
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    marks_o[i] <= 1'b0;
      else if (host_hit && acc_addr_i == ADDR_W'(i))  marks_o[i] <= !acc_we_i;
      else if (clr_i && clr_addr_i == ADDR_W'(i))     marks_o[i] <= 1'b0;
    end
  end

  // R1
  a_r1_read_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_hit && !acc_we_i) |=> marks_o[$past(acc_addr_i)]);
  // R4
  a_r4_check_unmarks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !marks_o[$past(clr_addr_i)]);
  // R9
  a_r9_stall_no_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clr_i) |=> $stable(marks_o));
endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int PERIOD = 1024,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic idle_i,
  output logic fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(PERIOD - 1));
  assign fire_o = en_i && idle_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !idle_i)  cnt_q <= '0;
    else if (at_end)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R10: a firing always launches a walk
  a_r10_fire_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !idle_i);
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              full_i,
  input  logic              exc_i,
  input  logic [N-1:0]      marks_i,
  output logic              arr_req_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic              arr_rvalid_i,
  input  logic [1:0]        arr_stat_i,
  input  logic [DATA_W-1:0] arr_fix_i,
  output logic              clr_o,
  output logic              idle_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ce_o,
  output logic              ue_o,
  output logic              discard_o,
  output logic              restart_o,
  output logic              exc_o,
  output logic              exc_ue_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N - 1);

  scr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              full_q, exc_q, ce_q, ue_q;
  logic [DATA_W-1:0] fix_q;
  logic              adv, last;
  logic              rd_seen_q;
  logic [ADDR_W-1:0] rd_last_q;

  assign last = (ptr_q == LAST);

  always_comb begin
    state_d   = state_q;
    arr_req_o = 1'b0;
    arr_we_o  = 1'b0;
    clr_o     = 1'b0;
    adv       = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_SCAN;
      S_SCAN: begin
        if (full_q || marks_i[ptr_q]) begin
          arr_req_o = 1'b1;
          clr_o     = 1'b1;
          state_d   = S_WAIT;
        end else begin
          adv = 1'b1;
        end
      end
      S_WAIT: begin
        if (arr_rvalid_i) begin
          if (arr_stat_i == CHK_CORR) state_d = S_FIX;
          else                        adv     = 1'b1;
        end
      end
      S_FIX: begin
        arr_req_o = 1'b1;
        arr_we_o  = 1'b1;
        adv       = 1'b1;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (adv) state_d = last ? S_DONE : S_SCAN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      full_q  <= 1'b0;
      exc_q   <= 1'b0;
      ce_q    <= 1'b0;
      ue_q    <= 1'b0;
      fix_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          ptr_q  <= '0;
          full_q <= full_i;
          exc_q  <= exc_i;
          ce_q   <= 1'b0;
          ue_q   <= 1'b0;
        end
      end else if (state_q != S_DONE && exc_i) begin
        exc_q <= 1'b1;
      end
      if (state_q == S_WAIT && arr_rvalid_i) begin
        fix_q <= arr_fix_i;
        if (arr_stat_i == CHK_CORR) ce_q <= 1'b1;
        if (arr_stat_i[1])          ue_q <= 1'b1;
      end
      if (adv && !last) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign arr_addr_o  = ptr_q;
  assign arr_wdata_o = fix_q;
  assign idle_o      = (state_q == S_IDLE);
  assign busy_o      = !idle_o;
  assign done_o      = (state_q == S_DONE);
  assign ce_o        = ce_q;
  assign ue_o        = ue_q;
  assign discard_o   = done_o && (ce_q || ue_q);
  assign restart_o   = done_o && ce_q && !ue_q;
  assign exc_o       = done_o && exc_q;
  assign exc_ue_o    = done_o && exc_q && ue_q;

  // Order tracking for the ascending-walk check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen_q <= 1'b0;
      rd_last_q <= '0;
    end else if (start_i && idle_o) begin
      rd_seen_q <= 1'b0;
    end else if (arr_req_o && !arr_we_o) begin
      rd_seen_q <= 1'b1;
      rd_last_q <= arr_addr_o;
    end
  end

  // R3
  a_r3_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && !arr_we_o && rd_seen_q) |-> (arr_addr_o > rd_last_q));
  // R5
  a_r5_fix_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && arr_we_o) |-> (arr_addr_o == $past(arr_addr_o)));
  // R6
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  a_r7_no_restart_on_ue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ue_o) |-> (discard_o && !restart_o));
  // R11
  a_r11_no_wb_on_ue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && arr_rvalid_i && arr_stat_i[1]) |=> !arr_we_o);
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq #(
  parameter int N      = 8,
  parameter int DATA_W = 32,
  parameter int PERIOD = 1024,
  parameter int ADDR_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              trig_seq_end_i,
  input  logic              trig_ctx_i,
  input  logic              trig_exc_i,
  input  logic              tmr_en_i,
  input  logic              full_mode_i,
  output logic              arr_req_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic              arr_rvalid_i,
  input  logic [1:0]        arr_stat_i,
  input  logic [DATA_W-1:0] arr_fix_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ce_o,
  output logic              ue_o,
  output logic              discard_o,
  output logic              restart_o,
  output logic              exc_o,
  output logic              exc_ue_o
);
  logic [N-1:0] marks;
  logic         clr, idle, tmr_fire, start;

  assign start = idle && (trig_seq_end_i || trig_ctx_i || trig_exc_i || tmr_fire);

  scrub_mark #(.N(N), .ADDR_W(ADDR_W)) i_mark (
    .clk_i, .rst_ni,
    .busy_i      (busy_o),
    .acc_valid_i, .acc_we_i, .acc_addr_i,
    .clr_i       (clr),
    .clr_addr_i  (arr_addr_o),
    .marks_o     (marks)
  );

  scrub_timer #(.PERIOD(PERIOD)) i_timer (
    .clk_i, .rst_ni,
    .en_i   (tmr_en_i),
    .idle_i (idle),
    .fire_o (tmr_fire)
  );

  scrub_ctrl #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i, .rst_ni,
    .start_i   (start),
    .full_i    (full_mode_i),
    .exc_i     (trig_exc_i),
    .marks_i   (marks),
    .arr_req_o, .arr_we_o, .arr_addr_o, .arr_wdata_o,
    .arr_rvalid_i, .arr_stat_i, .arr_fix_i,
    .clr_o     (clr),
    .idle_o    (idle),
    .busy_o, .done_o, .ce_o, .ue_o,
    .discard_o, .restart_o, .exc_o, .exc_ue_o
  );

  // R2
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (trig_seq_end_i || trig_ctx_i || trig_exc_i)) |=> busy_o);
endmodule

// File: tb/test_scrub_seq.sv
module test_scrub_seq;
  localparam int N = 8, DW = 8, AW = 3, PER = 20;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_we = 0;
  logic [AW-1:0] acc_addr = '0;
  logic t_seq = 0, t_ctx = 0, t_exc = 0, tmr_en = 0, full = 0;
  logic arr_req, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic arr_rvalid = 0;
  logic [1:0] arr_stat = '0;
  logic [DW-1:0] arr_fix = '0;
  logic busy, done, ce, ue, discard, restart, exc, exc_ue;

  int checks = 0, errors = 0, cycles = 0;
  logic [1:0] inj [N];
  int rd_log [32];
  int wr_addr [32];
  int wr_data [32];
  int rd_n = 0, wr_n = 0;
  int busy_cnt;
  logic s_done, s_ce, s_ue, s_dis, s_rst, s_exc, s_exc_ue;

  always #10 clk = ~clk;

  scrub_seq #(.N(N), .DATA_W(DW), .PERIOD(PER)) i_scrub_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(acc_valid), .acc_we_i(acc_we), .acc_addr_i(acc_addr),
    .trig_seq_end_i(t_seq), .trig_ctx_i(t_ctx), .trig_exc_i(t_exc),
    .tmr_en_i(tmr_en), .full_mode_i(full),
    .arr_req_o(arr_req), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .arr_rvalid_i(arr_rvalid), .arr_stat_i(arr_stat),
    .arr_fix_i(arr_fix),
    .busy_o(busy), .done_o(done), .ce_o(ce), .ue_o(ue),
    .discard_o(discard), .restart_o(restart), .exc_o(exc), .exc_ue_o(exc_ue)
  );

  // Array model: one-cycle response
  always @(posedge clk) begin
    arr_rvalid <= 1'b0;
    if (arr_req && !arr_we) begin
      arr_rvalid <= 1'b1;
      arr_stat   <= inj[arr_addr];
      arr_fix    <= 8'h5A ^ DW'(arr_addr);
      if (rd_n < 32) rd_log[rd_n] = int'(arr_addr);
      rd_n++;
    end
    if (arr_req && arr_we) begin
      if (wr_n < 32) begin
        wr_addr[wr_n] = int'(arr_addr);
        wr_data[wr_n] = int'(arr_wdata);
      end
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input int a);
    @(negedge clk);
    acc_valid = 1; acc_we = we; acc_addr = AW'(a);
  endtask

  task automatic acc_end();
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic set_marks(input int pat);
    for (int i = 0; i < N; i++) acc(!pat[i], i);
    acc_end();
  endtask

  // kind: 0 seq end, 1 ctx, 2 exception
  task automatic run_scrub(input int kind);
    @(negedge clk);
    rd_n = 0; wr_n = 0;
    s_done = 0; s_ce = 0; s_ue = 0; s_dis = 0; s_rst = 0; s_exc = 0; s_exc_ue = 0;
    t_seq = (kind == 0); t_ctx = (kind == 1); t_exc = (kind == 2);
    @(negedge clk);
    t_seq = 0; t_ctx = 0; t_exc = 0;
    busy_cnt = 0;
    while (busy && busy_cnt < 200) begin
      busy_cnt++;
      if (done) begin
        s_done = 1; s_ce = ce; s_ue = ue; s_dis = discard;
        s_rst = restart; s_exc = exc; s_exc_ue = exc_ue;
      end
      @(negedge clk);
    end
  endtask

  function automatic int popc(input int p);
    int c = 0;
    for (int i = 0; i < N; i++) c += p[i];
    return c;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) inj[i] = 2'b00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ce && !ue && !arr_req, "reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R4: all mark patterns
    for (int p = 0; p < 256; p++) begin
      int k, j;
      bit ok;
      set_marks(p);
      run_scrub(0);
      k = popc(p);
      j = 0; ok = (rd_n == k);
      for (int i = 0; i < N; i++)
        if (p[i]) begin
          if (j >= 32 || rd_log[j] != i) ok = 0;
          j++;
        end
      chk(ok, "R1/R3 read order", rd_n, k);
      chk(busy_cnt == N + k + 1, "R3 walk length", busy_cnt, N + k + 1);
      chk(s_done && !s_dis && !s_rst && !s_exc, "R7 clean walk", int'(s_dis), 0);
      run_scrub(1);
      chk(rd_n == 0, "R4 second walk unmarked", rd_n, 0);
      chk(busy_cnt == N + 1, "R4 second walk length", busy_cnt, N + 1);
    end

    // R5 R11 R6 R7: single errors at each address
    for (int a = 0; a < N; a++) begin
      for (int c = 1; c <= 2; c++) begin
        for (int i = 0; i < N; i++) inj[i] = 2'b00;
        inj[a] = 2'(c);
        set_marks(8'hFF);
        run_scrub(0);
        for (int i = 0; i < N; i++) inj[i] = 2'b00;
        if (c == 1) begin
          chk(wr_n == 1 && wr_addr[0] == a, "R5 write-back addr", wr_addr[0], a);
          chk(wr_data[0] == (8'h5A ^ a), "R5 write-back data", wr_data[0], 8'h5A ^ a);
          chk(busy_cnt == N + N + 1 + 1, "R5 walk length", busy_cnt, 2 * N + 2);
          chk(s_ce && !s_ue, "R6 ce flag", int'(s_ce), 1);
          chk(s_dis && s_rst, "R7 ce restart", int'(s_rst), 1);
          chk(ce && !ue, "R6 flags held", int'(ce), 1);
        end else begin
          chk(wr_n == 0, "R11 no write-back", wr_n, 0);
          chk(!s_ce && s_ue, "R6 ue flag", int'(s_ue), 1);
          chk(s_dis && !s_rst, "R7 ue discard only", int'(s_rst), 0);
        end
      end
    end

    // R7 R8: mixed errors under exception
    inj[2] = 2'b01; inj[5] = 2'b11;
    set_marks(8'hFF);
    run_scrub(2);
    for (int i = 0; i < N; i++) inj[i] = 2'b00;
    chk(s_ce && s_ue && s_dis && !s_rst, "R7 mixed", int'(s_rst), 0);
    chk(s_exc && s_exc_ue, "R8 exc with ue tag", int'(s_exc_ue), 1);
    chk(wr_n == 1 && wr_addr[0] == 2, "R11 only ce written", wr_n, 1);

    // R8: exception, no error, passes unchanged
    set_marks(8'h0F);
    run_scrub(2);
    chk(s_exc && !s_exc_ue && !s_dis, "R8 clean exception", int'(s_exc), 1);
    // R8: correctable under exception
    inj[1] = 2'b01;
    set_marks(8'h02);
    run_scrub(2);
    inj[1] = 2'b00;
    chk(s_exc && !s_exc_ue && s_rst, "R8 exc ce no tag", int'(s_exc_ue), 0);
    // non-exception trigger does not forward
    set_marks(8'h01);
    run_scrub(0);
    chk(!s_exc, "R8 no exc on seq end", int'(s_exc), 0);

    // R3: full mode checks all with no marks
    set_marks(8'h00);
    full = 1;
    run_scrub(1);
    full = 0;
    chk(rd_n == N, "R3 full mode reads", rd_n, N);
    chk(busy_cnt == 2 * N + 1, "R3 full mode length", busy_cnt, 2 * N + 1);

    // R9 R2 R8: host read and triggers during a walk
    set_marks(8'h00);
    @(negedge clk);
    t_seq = 1;
    @(negedge clk);
    t_seq = 0;
    chk(busy, "R2 busy after trigger", int'(busy), 1);
    acc_valid = 1; acc_we = 0; acc_addr = 3'd3; t_ctx = 1;
    @(negedge clk);
    t_ctx = 0; t_exc = 1;
    @(negedge clk);
    t_exc = 0; acc_valid = 0;
    s_exc = 0;
    while (busy) begin
      if (done) s_exc = exc;
      @(negedge clk);
    end
    chk(s_exc, "R8 exception during walk forwarded", int'(s_exc), 1);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 trigger during walk ignored", int'(busy), 0);
    run_scrub(0);
    chk(rd_n == 0, "R9 stalled read ignored", rd_n, 0);

    // R10: periodic timer
    begin
      int n = 0;
      @(negedge clk);
      tmr_en = 1;
      while (!busy && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(n == PER, "R10 timer period", n, PER);
      tmr_en = 0;
      while (busy) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule